// File: doc/BRIEF.md
# Remote Terminal Command Decoder and Subsystem Status Handler

This block sits behind the word validator of a dual-redundant serial command/response data bus remote terminal. Each validated 16-bit command word arrives as a one-cycle pulse, tagged with the bus it came from. The block first checks the command against the terminal's hardwired address pins. Those pins carry their own odd-parity bit. A parity fault raises an address-error flag and shuts off the receiver that delivered the word. Broadcast commands are accepted only when broadcast recognition is enabled for that bus.

An accepted command opens an in-command window. The window publishes the direction, subaddress and word-count fields, and it stays open until the message-end pulse arrives. A new accepted command supersedes the current one. Mode commands are those with subaddress 0 or 31. From them the block drives the subsystem strobes for synchronize, vector-word fetch, the subsystem reset pulse and the dynamic bus control request. It also keeps the four status bits that the subsystem controls:
- busy and service request, both sampled on the second falling edge of an internal 2 MHz clock;
- a sticky subsystem fault;
- dynamic bus control acceptance.

All pins are plain level or pulse signals. No data stream passes through the block, so it has no valid/ready interface and never applies back-pressure.

Top module: `rt_mode_status`

## Requirements
- R1: A command with `cmd_valid` high is accepted when its bits 15:11 equal `rt_addr`. On the next clock `in_cmd` is high, and `cmd_tr` (bit 10), `cmd_sa` (bits 9:5) and `cmd_wc` (bits 4:0) show the word's fields. A word carrying any other address (except 31, see R3) leaves `in_cmd` low.
- R2: `addr_err` is high whenever `rt_addr` and `rt_addr_par` together hold an even number of ones. A word that arrives on bus b while `addr_err` is high is not accepted and sets `rx_off[b]`. After that, every word on bus b is ignored until reset.
- R3: Address 31 is a broadcast. It is accepted, with `cmd_bcast` high, only when `bcast_en[b]` is high for the bus b it arrived on.
- R4: `cmd_is_mode` is high for subaddress 0 or 31. A `msg_end` pulse drops `in_cmd` on the next clock.
- R5: `sync_act` is high while `in_cmd` is high for either synchronize form. The form without data has direction 1 and mode code 5'b00001, with word-count bit 4 low. The form with data has direction 0 and mode code 5'b10001, with bit 4 high.
- R6: Transmit vector word has direction 1 and mode code 5'b10000, and is not broadcast. It raises `vec_en` for two clocks, the first clock with `vec_hi` high (high byte) and the second with `vec_hi` low.
- R7: Reset has direction 1 and mode code 5'b01000. When `msg_end` closes a reset command, `rst_pulse` goes high for `RST_CYC` clocks (500 ns by default).
- R8: `sts_busy` takes `ss_busy` at the second falling edge of the internal clock (period `INCLK_DIV` clocks) after acceptance. Later changes of `ss_busy` do not affect it. `data_go` is high only for a non-mode command after sampling, and only when `sts_busy` is low.
- R9: `sts_srq` takes `ss_srq` at the same sampling edge as busy and has no effect on `data_go`.
- R10: `sts_ssf` is set by `ss_err` or `hs_fail` and stays set. It is cleared only by reset or by the start of the `rst_pulse` of R7.
- R11: Dynamic bus control has direction 1 and mode code 5'b00000, and is not broadcast. It pulses `dbc_req` for one clock and sets `sts_dbca` only when `dbc_accept` is high as the command is accepted. `sts_dbca` clears whenever `dbc_accept` is low.
- R12: A command accepted while `in_cmd` is high replaces the published fields without a `msg_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high (power-up) |
| cmd_word | input | 16 | Validated command word |
| cmd_valid | input | 1 | One-cycle pulse: `cmd_word` is valid |
| cmd_bus | input | 1 | Bus the word arrived on |
| msg_end | input | 1 | One-cycle pulse: current message finished |
| rt_addr | input | 5 | Hardwired terminal address |
| rt_addr_par | input | 1 | Address parity pin (odd parity overall) |
| bcast_en | input | 2 | Broadcast recognition enable per bus |
| ss_busy | input | 1 | Subsystem busy request |
| ss_srq | input | 1 | Subsystem service request |
| ss_err | input | 1 | Subsystem error |
| hs_fail | input | 1 | Data handshake failure pulse |
| dbc_accept | input | 1 | Dynamic bus control acceptance |
| in_cmd | output | 1 | A command is being serviced |
| cmd_tr | output | 1 | Direction bit, 1 = terminal transmits |
| cmd_sa | output | 5 | Subaddress |
| cmd_wc | output | 5 | Word count or mode code |
| cmd_is_mode | output | 1 | Current command is a mode command |
| cmd_bcast | output | 1 | Current command is a broadcast |
| data_go | output | 1 | Ordinary data transfer permitted |
| addr_err | output | 1 | Address parity fault |
| rx_off | output | 2 | Receiver shut off, per bus |
| sync_act | output | 1 | Synchronize mode command active |
| vec_en | output | 1 | Vector word byte fetch enable |
| vec_hi | output | 1 | Vector fetch of the high byte |
| rst_pulse | output | 1 | Subsystem reset pulse |
| dbc_req | output | 1 | Dynamic bus control request pulse |
| sts_busy | output | 1 | Busy status bit |
| sts_srq | output | 1 | Service request status bit |
| sts_ssf | output | 1 | Subsystem flag status bit |
| sts_dbca | output | 1 | Dynamic bus control acceptance bit (bit 18) |

## Verification
The assertions assume that `cmd_valid`, `msg_end` and `hs_fail` are single-cycle pulses. They also assume that `msg_end` never coincides with `cmd_valid`, and that the address pins stay still while a command is in service. The stimulus drives all of these on falling clock edges. It holds each pulse for exactly one cycle and leaves several idle cycles between commands. It changes the address parity pin only while no command is in service, so that R2 is exercised without breaking the assumptions that the checks of R1 and R3 rely on.

// File: rtl/rtmc_pkg.sv
package rtmc_pkg;
  localparam int FIELD_W = 5;
  localparam logic [FIELD_W-1:0] BCAST_ADDR = 5'd31;
  localparam logic [FIELD_W-1:0] SA_MODE_LO = 5'd0;
  localparam logic [FIELD_W-1:0] SA_MODE_HI = 5'd31;
  localparam logic [FIELD_W-1:0] MC_DBC     = 5'b00000;
  localparam logic [FIELD_W-1:0] MC_SYNC    = 5'b00001;
  localparam logic [FIELD_W-1:0] MC_RESET   = 5'b01000;
  localparam logic [FIELD_W-1:0] MC_VECTOR  = 5'b10000;
  localparam logic [FIELD_W-1:0] MC_SYNC_D  = 5'b10001;

  typedef enum logic [2:0] {
    MK_NONE, MK_SYNC, MK_SYNC_D, MK_VECTOR, MK_RESET, MK_DBC, MK_OTHER
  } mode_kind_t;

  typedef struct packed {
    logic [FIELD_W-1:0] addr;
    logic               tr;
    logic [FIELD_W-1:0] sa;
    logic [FIELD_W-1:0] wc;
  } cmd_t;
endpackage

// File: rtl/rtmc_addr_gate.sv
module rtmc_addr_gate
  import rtmc_pkg::*;
#(
  parameter int NBUS = 2,
  localparam int BUS_W = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [BUS_W-1:0]   bus,
  input  logic [FIELD_W-1:0] addr_field,
  input  logic [FIELD_W-1:0] rt_addr,
  input  logic               rt_addr_par,
  input  logic [NBUS-1:0]    bcast_en,
  output logic               addr_err,
  output logic [NBUS-1:0]    rx_off,
  output logic               hit,
  output logic               hit_bcast
);
  logic par_ok, own;

  assign par_ok    = ^{rt_addr, rt_addr_par};
  assign addr_err  = ~par_ok;
  assign own       = (addr_field == rt_addr);
  assign hit_bcast = (addr_field == BCAST_ADDR) && bcast_en[bus];
  assign hit       = word_valid && par_ok && !rx_off[bus] && (own || hit_bcast);

  always_ff @(posedge clk) begin
    if (rst) rx_off <= '0;
    else if (word_valid && !par_ok) rx_off[bus] <= 1'b1;
  end
endmodule

// File: rtl/rtmc_mode_dec.sv
module rtmc_mode_dec
  import rtmc_pkg::*;
(
  input  cmd_t       cmd,
  input  logic       bcast,
  output logic       is_mode,
  output mode_kind_t kind
);
  always_comb begin
    is_mode = (cmd.sa == SA_MODE_LO) || (cmd.sa == SA_MODE_HI);
    kind    = MK_NONE;
    if (is_mode) begin
      kind = MK_OTHER;
      if (cmd.tr && cmd.wc == MC_SYNC)                 kind = MK_SYNC;
      else if (!cmd.tr && cmd.wc == MC_SYNC_D)         kind = MK_SYNC_D;
      else if (cmd.tr && cmd.wc == MC_VECTOR && !bcast) kind = MK_VECTOR;
      else if (cmd.tr && cmd.wc == MC_RESET)           kind = MK_RESET;
      else if (cmd.tr && cmd.wc == MC_DBC && !bcast)    kind = MK_DBC;
    end
  end
endmodule

// File: rtl/rtmc_status.sv
module rtmc_status (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic accept,
  input  logic dbc_cmd,
  input  logic dbc_accept,
  input  logic ss_busy,
  input  logic ss_srq,
  input  logic ss_err,
  input  logic hs_fail,
  input  logic fault_clr,
  output logic sts_busy,
  output logic sts_srq,
  output logic sts_ssf,
  output logic sts_dbca,
  output logic sampled
);
  logic armed, seen1;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0; seen1 <= 1'b0; sampled <= 1'b0;
      sts_busy <= 1'b0; sts_srq <= 1'b0;
    end else if (accept) begin
      armed <= 1'b1; seen1 <= 1'b0; sampled <= 1'b0;
      sts_busy <= 1'b0; sts_srq <= 1'b0;
    end else if (armed && tick) begin
      if (!seen1) seen1 <= 1'b1;
      else begin
        sts_busy <= ss_busy;
        sts_srq  <= ss_srq;
        sampled  <= 1'b1;
        armed    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sts_dbca <= 1'b0;
    else if (accept) sts_dbca <= dbc_cmd && dbc_accept;
    else if (!dbc_accept) sts_dbca <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) sts_ssf <= 1'b0;
    else if (fault_clr) sts_ssf <= 1'b0;
    else if (ss_err || hs_fail) sts_ssf <= 1'b1;
  end

  AST_SSF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts_ssf && !fault_clr) |=> sts_ssf); // R10
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (sampled && !accept) |=> $stable(sts_busy) && $stable(sts_srq)); // R8
endmodule

// File: rtl/rt_mode_status.sv
module rt_mode_status
  import rtmc_pkg::*;
#(
  parameter int NBUS      = 2,
  parameter int INCLK_DIV = 25,
  parameter int RST_CYC   = 25,
  localparam int BUS_W = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int DIV_W = (INCLK_DIV > 1) ? $clog2(INCLK_DIV) : 1,
  localparam int RST_W = $clog2(RST_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        cmd_word,
  input  logic               cmd_valid,
  input  logic [BUS_W-1:0]   cmd_bus,
  input  logic               msg_end,
  input  logic [FIELD_W-1:0] rt_addr,
  input  logic               rt_addr_par,
  input  logic [NBUS-1:0]    bcast_en,
  input  logic               ss_busy,
  input  logic               ss_srq,
  input  logic               ss_err,
  input  logic               hs_fail,
  input  logic               dbc_accept,
  output logic               in_cmd,
  output logic               cmd_tr,
  output logic [FIELD_W-1:0] cmd_sa,
  output logic [FIELD_W-1:0] cmd_wc,
  output logic               cmd_is_mode,
  output logic               cmd_bcast,
  output logic               data_go,
  output logic               addr_err,
  output logic [NBUS-1:0]    rx_off,
  output logic               sync_act,
  output logic               vec_en,
  output logic               vec_hi,
  output logic               rst_pulse,
  output logic               dbc_req,
  output logic               sts_busy,
  output logic               sts_srq,
  output logic               sts_ssf,
  output logic               sts_dbca
);
  cmd_t       in_w, cur;
  mode_kind_t nx_kind, cur_kind;
  logic       nx_mode, hit, hit_bcast, tick, sampled, end_now, fault_clr;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       vec_cnt;
  logic [RST_W-1:0] rst_cnt;

  assign in_w = cmd_t'(cmd_word);

  // free-running internal clock; tick marks its falling edge
  always_ff @(posedge clk) begin
    if (rst || tick) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == DIV_W'(INCLK_DIV - 1));

  rtmc_addr_gate #(.NBUS(NBUS)) u_gate (
    .clk(clk), .rst(rst), .word_valid(cmd_valid), .bus(cmd_bus),
    .addr_field(in_w.addr), .rt_addr(rt_addr), .rt_addr_par(rt_addr_par),
    .bcast_en(bcast_en), .addr_err(addr_err), .rx_off(rx_off),
    .hit(hit), .hit_bcast(hit_bcast));

  rtmc_mode_dec u_dec (.cmd(in_w), .bcast(hit_bcast), .is_mode(nx_mode), .kind(nx_kind));

  assign end_now   = msg_end && in_cmd && !hit;
  assign fault_clr = end_now && (cur_kind == MK_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cmd <= 1'b0; cur <= '0; cmd_bcast <= 1'b0;
      cmd_is_mode <= 1'b0; cur_kind <= MK_NONE;
    end else if (hit) begin
      in_cmd <= 1'b1; cur <= in_w; cmd_bcast <= hit_bcast;
      cmd_is_mode <= nx_mode; cur_kind <= nx_kind;
    end else if (msg_end) begin
      in_cmd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_cnt <= '0; rst_cnt <= '0; dbc_req <= 1'b0;
    end else begin
      if (hit && nx_kind == MK_VECTOR) vec_cnt <= 2'd2;
      else if (vec_cnt != 0) vec_cnt <= vec_cnt - 1'b1;
      if (fault_clr) rst_cnt <= RST_W'(RST_CYC);
      else if (rst_cnt != 0) rst_cnt <= rst_cnt - 1'b1;
      dbc_req <= hit && (nx_kind == MK_DBC) && dbc_accept;
    end
  end

  rtmc_status u_sts (
    .clk(clk), .rst(rst), .tick(tick), .accept(hit),
    .dbc_cmd(nx_kind == MK_DBC), .dbc_accept(dbc_accept),
    .ss_busy(ss_busy), .ss_srq(ss_srq), .ss_err(ss_err), .hs_fail(hs_fail),
    .fault_clr(fault_clr), .sts_busy(sts_busy), .sts_srq(sts_srq),
    .sts_ssf(sts_ssf), .sts_dbca(sts_dbca), .sampled(sampled));

  assign cmd_tr    = cur.tr;
  assign cmd_sa    = cur.sa;
  assign cmd_wc    = cur.wc;
  assign sync_act  = in_cmd && (cur_kind == MK_SYNC || cur_kind == MK_SYNC_D);
  assign vec_en    = (vec_cnt != 0);
  assign vec_hi    = (vec_cnt == 2'd2);
  assign rst_pulse = (rst_cnt != 0);
  assign data_go   = in_cmd && !cmd_is_mode && sampled && !sts_busy;

  AST_PARERR_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && addr_err) |=> !$rose(in_cmd)); // R2
  AST_VEC_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (vec_en && vec_hi) |=> (vec_en && !vec_hi)); // R6
  AST_RST_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pulse) |-> $past(msg_end)); // R7
  AST_DBC_GATED: assert property (@(posedge clk) disable iff (rst)
    dbc_req |-> $past(dbc_accept)); // R11
endmodule

// File: tb/rt_mode_status_bench.sv
module rt_mode_status_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] cmd_word = '0;
  logic cmd_valid = 0, cmd_bus = 0, msg_end = 0;
  logic [4:0] rt_addr = 5'd5;
  logic rt_addr_par = 1'b1;
  logic [1:0] bcast_en = 2'b01;
  logic ss_busy = 0, ss_srq = 0, ss_err = 0, hs_fail = 0, dbc_accept = 0;
  logic in_cmd, cmd_tr, cmd_is_mode, cmd_bcast, data_go, addr_err;
  logic [4:0] cmd_sa, cmd_wc;
  logic [1:0] rx_off;
  logic sync_act, vec_en, vec_hi, rst_pulse, dbc_req;
  logic sts_busy, sts_srq, sts_ssf, sts_dbca;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rt_mode_status u_rt_mode_status (.*);

  // entry: {cmd[15:0], bus, exp in_cmd, exp sync_act, exp vec_en, exp cmd_bcast}
  localparam logic [20:0] VEC [8] = '{
    {5'd5,  1'b0, 5'd3,  5'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd6,  1'b0, 5'd3,  5'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd31, 1'b0, 5'd3,  5'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd31, 1'b0, 5'd3,  5'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd5,  1'b1, 5'd0,  5'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd5,  1'b0, 5'd31, 5'd17, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd5,  1'b1, 5'd0,  5'd16, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd31, 1'b1, 5'd0,  5'd16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic b);
    @(negedge clk); cmd_word = w; cmd_bus = b; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic close_msg();
    @(negedge clk); msg_end = 1'b1;
    @(negedge clk); msg_end = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset in_cmd", 32'(in_cmd), 0);
    chk("reset status", 32'({sts_busy, sts_srq, sts_ssf, sts_dbca}), 0);
    chk("reset strobes", 32'({rst_pulse, dbc_req, vec_en, sync_act}), 0);
    chk("reset addr", 32'({addr_err, rx_off}), 0);

    // table walk: R1 R3 R5 R6
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][20:5], VEC[i][4]);
      chk($sformatf("R1/R3 vec%0d in_cmd", i), 32'(in_cmd), 32'(VEC[i][3]));
      chk($sformatf("R5 vec%0d sync", i), 32'(sync_act), 32'(VEC[i][2]));
      chk($sformatf("R6 vec%0d vec_en", i), 32'(vec_en), 32'(VEC[i][1]));
      if (VEC[i][3]) chk($sformatf("R3 vec%0d bcast", i), 32'(cmd_bcast), 32'(VEC[i][0]));
      if (VEC[i][1]) begin
        chk("R6 high byte first", 32'(vec_hi), 1);
        @(negedge clk);
        chk("R6 low byte second", 32'({vec_en, vec_hi}), 32'(2'b10));
      end
      close_msg();
    end

    // R1 R4 fields, R8 sampling delay
    send({5'd5, 1'b1, 5'd9, 5'd12}, 1'b1);
    chk("R1 fields", 32'({cmd_tr, cmd_sa, cmd_wc}), 32'({1'b1, 5'd9, 5'd12}));
    chk("R4 not mode", 32'(cmd_is_mode), 0);
    chk("R8 no transfer before sample", 32'(data_go), 0);
    repeat (60) @(negedge clk);
    chk("R8 transfer when not busy", 32'(data_go), 1);
    ss_busy = 1'b1;
    repeat (60) @(negedge clk);
    chk("R8 late busy ignored", 32'(sts_busy), 0);
    // R12 superseding command
    ss_busy = 1'b0;
    send({5'd5, 1'b0, 5'd31, 5'd2}, 1'b0);
    chk("R12 superseded sa", 32'(cmd_sa), 31);
    chk("R4 mode flag", 32'(cmd_is_mode), 1);
    @(negedge clk); msg_end = 1'b1; @(negedge clk); msg_end = 1'b0;
    chk("R4 msg_end closes", 32'(in_cmd), 0);
    repeat (3) @(negedge clk);

    // R8 R9 busy and service request sampled
    ss_busy = 1'b1; ss_srq = 1'b1;
    send({5'd5, 1'b0, 5'd3, 5'd4}, 1'b0);
    repeat (60) @(negedge clk);
    ss_busy = 1'b0; ss_srq = 1'b0;
    @(negedge clk);
    chk("R8 busy sampled", 32'(sts_busy), 1);
    chk("R9 srq sampled", 32'(sts_srq), 1);
    chk("R8 busy blocks transfer", 32'(data_go), 0);
    close_msg();
    ss_srq = 1'b1;
    send({5'd5, 1'b0, 5'd3, 5'd4}, 1'b0);
    repeat (60) @(negedge clk);
    chk("R9 srq leaves transfer", 32'({sts_srq, data_go}), 32'(2'b11));
    ss_srq = 1'b0;
    close_msg();

    // R10 sticky fault, R7 reset pulse
    @(negedge clk); ss_err = 1'b1; @(negedge clk); ss_err = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 fault from ss_err sticks", 32'(sts_ssf), 1);
    send({5'd5, 1'b1, 5'd0, 5'd8}, 1'b0);
    chk("R7 no pulse before end", 32'(rst_pulse), 0);
    @(negedge clk); msg_end = 1'b1; @(negedge clk); msg_end = 1'b0;
    chk("R10 fault cleared by reset cmd", 32'(sts_ssf), 0);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      if (rst_pulse) n++;
      @(negedge clk);
    end
    chk("R7 pulse width", 32'(n), 25);
    @(negedge clk); hs_fail = 1'b1; @(negedge clk); hs_fail = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 fault from handshake", 32'(sts_ssf), 1);

    // R11 dynamic bus control
    dbc_accept = 1'b1;
    send({5'd5, 1'b1, 5'd0, 5'd0}, 1'b0);
    chk("R11 request pulse", 32'({dbc_req, sts_dbca}), 32'(2'b11));
    @(negedge clk);
    chk("R11 request one clock", 32'(dbc_req), 0);
    dbc_accept = 1'b0;
    @(negedge clk);
    chk("R11 bit cleared without acceptance", 32'(sts_dbca), 0);
    close_msg();
    send({5'd5, 1'b1, 5'd0, 5'd0}, 1'b0);
    chk("R11 request inhibited", 32'({dbc_req, sts_dbca}), 0);
    close_msg();

    // R2 parity fault
    rt_addr_par = 1'b0;
    @(negedge clk);
    chk("R2 addr_err", 32'(addr_err), 1);
    send({5'd5, 1'b0, 5'd3, 5'd4}, 1'b1);
    chk("R2 not accepted", 32'(in_cmd), 0);
    chk("R2 receiver off", 32'(rx_off), 32'(2'b10));
    rt_addr_par = 1'b1;
    send({5'd5, 1'b0, 5'd3, 5'd4}, 1'b1);
    chk("R2 off bus ignored", 32'(in_cmd), 0);
    send({5'd5, 1'b0, 5'd3, 5'd4}, 1'b0);
    chk("R2 other bus works", 32'(in_cmd), 1);
    close_msg();

    finish_run();
  end
endmodule